// File: doc/BRIEF.md
# Dual-Slot Instruction Issue Dispatcher

This block accepts one 64-bit instruction word and uses two format bits in that word to decide how to issue it. It can issue the whole word as one long instruction. It can issue the two 32-bit halves one after the other, in either order. It can also issue both halves at the same time.

Two execution units sit behind request/acknowledge handshakes:

- The memory unit always receives the upper half, or the whole word in long mode.
- The integer unit always receives the lower half.

Each unit can return a branch target, marked by its own valid bit, and a kill flag when it acknowledges.

The dispatcher does three things:

- It cancels the second half of a sequential pair when the first half branches or kills.
- It merges the branch targets of a parallel pair, and reports an error when both halves branch.
- It pulses a commit strobe for each retired slot and a done strobe when the whole word has retired.

Top module: `dual_issue_dispatch`

## Requirements
- R1: A `go` pulse while `busy` is low captures `insn` and raises `busy`. The format is `{insn[63], insn[31]}`: 0 is long, 1 is low-half-first, 2 is high-half-first, 3 is parallel. A `go` pulse while `busy` is high is ignored.
- R2: Format 0 issues the full 64-bit word on the memory unit with `mu_long` high. It retires with one commit, and its branch supplies the next address.
- R3: Format 1 first issues `insn[31:0]` on the integer unit. It then issues `insn[63:32]`, zero-extended, on the memory unit with `slot_any` high.
- R4: Format 2 first issues `insn[63:32]`, zero-extended, on the memory unit. It then issues `insn[31:0]` on the integer unit with `slot_any` high.
- R5: In formats 1 and 2, the second slot is never requested when the first slot acknowledges with a branch or with its kill flag set. The next address then comes from the first slot. Otherwise it comes from the second slot.
- R6: Format 3 raises both requests together. Each request stays high until its own acknowledge and then drops. One commit follows the later acknowledge.
- R7: In format 3, a single branching slot supplies `nxt_addr` with `nxt_valid` high. If both slots branch, `err` is high, `nxt_valid` is low and no branch is taken. The kill flag has no effect in this format.
- R8: `commit` pulses for one cycle in the cycle after each retiring acknowledge. A sequential pair that runs to completion gives two commits. A cancelled pair gives one.
- R9: `done` pulses for one cycle together with the last commit. At that point `busy` is already low and `nxt_valid`, `nxt_addr` and `err` are valid. These three results hold until the next done.
- R10: After reset, `busy`, both requests, `commit`, `done`, `nxt_valid` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start a new instruction word |
| insn | input | 64 | Instruction word |
| busy | output | 1 | A word is in flight |
| mu_req | output | 1 | Memory unit request |
| mu_long | output | 1 | Memory unit carries a long instruction |
| mu_insn | output | 64 | Memory unit instruction |
| mu_ack | input | 1 | Memory unit acknowledge |
| mu_br_valid | input | 1 | Memory unit produced a branch |
| mu_br_addr | input | 32 | Memory unit branch target |
| mu_kill | input | 1 | Memory unit cancels the following slot |
| iu_req | output | 1 | Integer unit request |
| iu_insn | output | 32 | Integer unit instruction |
| iu_ack | input | 1 | Integer unit acknowledge |
| iu_br_valid | input | 1 | Integer unit produced a branch |
| iu_br_addr | input | 32 | Integer unit branch target |
| iu_kill | input | 1 | Integer unit cancels the following slot |
| slot_any | output | 1 | Current request is the unconstrained second slot |
| commit | output | 1 | Write-commit strobe |
| done | output | 1 | Word fully retired |
| nxt_valid | output | 1 | Next address is a branch target |
| nxt_addr | output | 32 | Next address |
| err | output | 1 | Both parallel slots branched |

## Verification
Timing from the `go` edge:

- The first requests appear in the cycle after the edge that samples `go`.
- An acknowledge counts in the same cycle its request is high.
- `commit`, `done` and the next-address results change at the clock edge that samples the retiring acknowledge.

The bench sets the per-unit acknowledge latency from each vector. It samples every request, acknowledge and strobe on the falling edge, so each of them is seen in the cycle it is due. It compares the results only after `done` has been seen, plus a few idle cycles. This lets a missing or extra commit, request or done show up in the counts.

// File: rtl/dual_issue_dispatch.sv
module dual_issue_dispatch #(
  parameter int IW = 64,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [IW-1:0] insn,
  output logic          busy,
  output logic          mu_req,
  output logic          mu_long,
  output logic [IW-1:0] mu_insn,
  input  logic          mu_ack,
  input  logic          mu_br_valid,
  input  logic [AW-1:0] mu_br_addr,
  input  logic          mu_kill,
  output logic          iu_req,
  output logic [IW/2-1:0] iu_insn,
  input  logic          iu_ack,
  input  logic          iu_br_valid,
  input  logic [AW-1:0] iu_br_addr,
  input  logic          iu_kill,
  output logic          slot_any,
  output logic          commit,
  output logic          done,
  output logic          nxt_valid,
  output logic [AW-1:0] nxt_addr,
  output logic          err
);
  localparam int HW = IW / 2;
  typedef enum logic [1:0] {IDLE, FIRST, SECOND, PAR} st_t;

  st_t st;
  logic [IW-1:0] w;
  logic [1:0] fmtr;
  logic mu_pend, iu_pend, bv_m, bv_i;
  logic [AW-1:0] ba_m, ba_i;

  wire first_iu = (fmtr == 2'd1);
  wire act_iu   = (st == FIRST) == first_iu;
  wire act_ack  = act_iu ? iu_ack : mu_ack;
  wire act_bv   = act_iu ? iu_br_valid : mu_br_valid;
  wire act_kill = act_iu ? iu_kill : mu_kill;
  wire [AW-1:0] act_ba = act_iu ? iu_br_addr : mu_br_addr;

  wire m_fin = !mu_pend || mu_ack;
  wire i_fin = !iu_pend || iu_ack;
  wire mbv = mu_pend ? mu_br_valid : bv_m;
  wire ibv = iu_pend ? iu_br_valid : bv_i;
  wire [AW-1:0] mba = mu_pend ? mu_br_addr : ba_m;
  wire [AW-1:0] iba = iu_pend ? iu_br_addr : ba_i;

  assign busy     = (st != IDLE);
  assign slot_any = (st == SECOND);
  assign mu_req   = (st == FIRST && !first_iu) || (st == SECOND && first_iu) || (st == PAR && mu_pend);
  assign iu_req   = (st == FIRST && first_iu) || (st == SECOND && !first_iu) || (st == PAR && iu_pend);
  assign mu_long  = (fmtr == 2'd0);
  assign mu_insn  = mu_long ? w : {{HW{1'b0}}, w[IW-1:HW]};
  assign iu_insn  = w[HW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      w <= '0;
      fmtr <= '0;
      mu_pend <= 1'b0;
      iu_pend <= 1'b0;
      bv_m <= 1'b0;
      bv_i <= 1'b0;
      ba_m <= '0;
      ba_i <= '0;
      commit <= 1'b0;
      done <= 1'b0;
      nxt_valid <= 1'b0;
      nxt_addr <= '0;
      err <= 1'b0;
    end else begin
      commit <= 1'b0;
      done <= 1'b0;
      case (st)
        IDLE: if (go) begin
          w <= insn;
          fmtr <= {insn[IW-1], insn[HW-1]};
          mu_pend <= 1'b1;
          iu_pend <= 1'b1;
          st <= ({insn[IW-1], insn[HW-1]} == 2'd3) ? PAR : FIRST;
        end
        FIRST: if (act_ack) begin
          commit <= 1'b1;
          if (fmtr == 2'd0 || act_bv || act_kill) begin
            done <= 1'b1;
            nxt_valid <= act_bv;
            nxt_addr <= act_ba;
            err <= 1'b0;
            st <= IDLE;
          end else begin
            st <= SECOND;
          end
        end
        SECOND: if (act_ack) begin
          commit <= 1'b1;
          done <= 1'b1;
          nxt_valid <= act_bv;
          nxt_addr <= act_ba;
          err <= 1'b0;
          st <= IDLE;
        end
        PAR: begin
          if (mu_pend && mu_ack) begin
            mu_pend <= 1'b0;
            bv_m <= mu_br_valid;
            ba_m <= mu_br_addr;
          end
          if (iu_pend && iu_ack) begin
            iu_pend <= 1'b0;
            bv_i <= iu_br_valid;
            ba_i <= iu_br_addr;
          end
          if (m_fin && i_fin) begin
            commit <= 1'b1;
            done <= 1'b1;
            err <= mbv && ibv;
            nxt_valid <= mbv ^ ibv;
            nxt_addr <= mbv ? mba : iba;
            st <= IDLE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dual_issue_dispatch_chk.sv
module dual_issue_dispatch_chk (
  input logic clk,
  input logic rst_n,
  input logic go,
  input logic busy,
  input logic mu_req,
  input logic mu_ack,
  input logic iu_req,
  input logic iu_ack,
  input logic slot_any,
  input logic commit,
  input logic done,
  input logic nxt_valid,
  input logic err
);
  assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy) |=> busy);
  assert_any_one_unit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_any |-> (mu_req != iu_req));
  assert_mu_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mu_req && !mu_ack) |=> mu_req);
  assert_iu_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (iu_req && !iu_ack) |=> iu_req);
  assert_err_no_branch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !nxt_valid);
  assert_done_with_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (commit && !busy));
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mu_req && !iu_req));
endmodule

bind dual_issue_dispatch dual_issue_dispatch_chk u_chk (.*);

// File: tb/dual_issue_dispatch_bench.sv
`timescale 1ns/1ps
module dual_issue_dispatch_bench;
  logic clk = 0, rst_n = 0, go = 0;
  logic [63:0] insn = '0;
  logic busy, mu_req, mu_long, mu_ack, mu_br_valid, mu_kill;
  logic iu_req, iu_ack, iu_br_valid, iu_kill;
  logic slot_any, commit, done, nxt_valid, err;
  logic [63:0] mu_insn;
  logic [31:0] iu_insn, mu_br_addr, iu_br_addr, nxt_addr;

  typedef struct packed {
    logic [1:0] fmt;
    logic mbv, mk, ibv, ik;
    logic [1:0] md, id;
    logic em, ei;
    logic [1:0] ec;
    logic env, esel, eerr;
    logic [1:0] efirst;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{2'd0,1'b0,1'b0,1'b0,1'b0,2'd1,2'd0,1'b1,1'b0,2'd1,1'b0,1'b0,1'b0,2'd0},
    '{2'd0,1'b1,1'b0,1'b0,1'b0,2'd0,2'd0,1'b1,1'b0,2'd1,1'b1,1'b0,1'b0,2'd0},
    '{2'd1,1'b0,1'b0,1'b0,1'b0,2'd0,2'd1,1'b1,1'b1,2'd2,1'b0,1'b0,1'b0,2'd1},
    '{2'd1,1'b0,1'b0,1'b1,1'b0,2'd0,2'd0,1'b0,1'b1,2'd1,1'b1,1'b1,1'b0,2'd1},
    '{2'd1,1'b0,1'b0,1'b0,1'b1,2'd0,2'd2,1'b0,1'b1,2'd1,1'b0,1'b0,1'b0,2'd1},
    '{2'd1,1'b1,1'b0,1'b0,1'b0,2'd2,2'd0,1'b1,1'b1,2'd2,1'b1,1'b0,1'b0,2'd1},
    '{2'd2,1'b0,1'b0,1'b0,1'b0,2'd1,2'd1,1'b1,1'b1,2'd2,1'b0,1'b0,1'b0,2'd0},
    '{2'd2,1'b1,1'b0,1'b0,1'b0,2'd0,2'd0,1'b1,1'b0,2'd1,1'b1,1'b0,1'b0,2'd0},
    '{2'd2,1'b0,1'b1,1'b0,1'b0,2'd2,2'd0,1'b1,1'b0,2'd1,1'b0,1'b0,1'b0,2'd0},
    '{2'd2,1'b0,1'b0,1'b1,1'b0,2'd0,2'd2,1'b1,1'b1,2'd2,1'b1,1'b1,1'b0,2'd0},
    '{2'd3,1'b0,1'b0,1'b0,1'b0,2'd1,2'd2,1'b1,1'b1,2'd1,1'b0,1'b0,1'b0,2'd2},
    '{2'd3,1'b1,1'b0,1'b0,1'b0,2'd2,2'd0,1'b1,1'b1,2'd1,1'b1,1'b0,1'b0,2'd2},
    '{2'd3,1'b0,1'b1,1'b1,1'b0,2'd0,2'd1,1'b1,1'b1,2'd1,1'b1,1'b1,1'b0,2'd2},
    '{2'd3,1'b1,1'b0,1'b1,1'b0,2'd1,2'd1,1'b1,1'b1,2'd1,1'b0,1'b0,1'b1,2'd2},
    '{2'd0,1'b0,1'b1,1'b0,1'b0,2'd0,2'd0,1'b1,1'b0,2'd1,1'b0,1'b0,1'b0,2'd0}
  };

  vec_t cur = '0;
  logic [63:0] word = '0;
  int idx = 0, mcnt = 0, icnt = 0;
  int checks = 0, fails = 0;
  int mu_cnt, iu_cnt, com_cnt, done_cnt, bad_insn;
  logic got_nv, got_err;
  logic [31:0] got_addr;

  always #2.5 clk = ~clk;

  assign mu_ack = mu_req && (mcnt == int'(cur.md));
  assign iu_ack = iu_req && (icnt == int'(cur.id));
  assign mu_br_valid = cur.mbv;
  assign iu_br_valid = cur.ibv;
  assign mu_kill = cur.mk;
  assign iu_kill = cur.ik;
  assign mu_br_addr = 32'h1000 + idx;
  assign iu_br_addr = 32'h2000 + idx;

  always @(posedge clk) begin
    mcnt <= (!mu_req || mu_ack) ? 0 : mcnt + 1;
    icnt <= (!iu_req || iu_ack) ? 0 : icnt + 1;
  end

  dual_issue_dispatch u_dual_issue_dispatch (.*);

  always @(negedge clk) if (rst_n) begin
    if (mu_req && mu_ack) begin
      mu_cnt++;
      if (mu_insn !== (cur.fmt == 2'd0 ? word : {32'h0, word[63:32]}) ||
          mu_long !== (cur.fmt == 2'd0) || slot_any !== (cur.fmt == 2'd1)) bad_insn++;
    end
    if (iu_req && iu_ack) begin
      iu_cnt++;
      if (iu_insn !== word[31:0] || slot_any !== (cur.fmt == 2'd2)) bad_insn++;
    end
    if (commit) com_cnt++;
    if (done) begin
      done_cnt++;
      got_nv = nxt_valid; got_addr = nxt_addr; got_err = err;
      if (busy) bad_insn++;
    end
  end

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s vector %0d: actual %0h expected %0h", req, idx, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int n, input logic inject);
    logic [1:0] first;
    cur = v; idx = n;
    word = {v.fmt[1], 31'(n * 37 + 5), v.fmt[0], 31'(n * 91 + 3)};
    mu_cnt = 0; iu_cnt = 0; com_cnt = 0; done_cnt = 0; bad_insn = 0;
    got_nv = 0; got_err = 0; got_addr = '0;
    insn = word; go = 1;
    @(negedge clk);
    go = 0;
    first = {iu_req, mu_req};
    check(busy === 1'b1, "R1", busy, 1);
    check(first == (v.efirst == 2'd0 ? 2'b01 : v.efirst == 2'd1 ? 2'b10 : 2'b11),
          v.fmt == 2'd1 ? "R3" : v.fmt == 2'd3 ? "R6" : "R4", first, v.efirst);
    if (inject) begin
      insn = {1'b1, 31'h1234567, 1'b1, 31'h7654321}; go = 1;
      @(negedge clk);
      go = 0;
    end
    for (int k = 0; k < 40 && done_cnt == 0; k++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(done_cnt == 1, "R9", done_cnt, 1);
    check(bad_insn == 0, v.fmt == 2'd0 ? "R2" : "R4", bad_insn, 0);
    check(mu_cnt == int'(v.em) && iu_cnt == int'(v.ei), "R5", {mu_cnt[7:0], iu_cnt[7:0]}, {v.em, 7'b0, v.ei});
    check(com_cnt == int'(v.ec), "R8", com_cnt, v.ec);
    check(got_nv === v.env, "R7", got_nv, v.env);
    if (v.env)
      check(got_addr === (v.esel ? 32'h2000 + n : 32'h1000 + n), "R5", got_addr,
            v.esel ? 32'h2000 + n : 32'h1000 + n);
    check(got_err === v.eerr, "R7", got_err, v.eerr);
    check(busy === 1'b0, "R9", busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check({busy, mu_req, iu_req, commit, done, nxt_valid, err} === 7'b0, "R10",
          {busy, mu_req, iu_req, commit, done, nxt_valid, err}, 0);
    for (int i = 0; i < NV; i++) run_vec(VEC[i], i, 1'b0);
    // R1: go while busy is ignored
    run_vec('{2'd2,1'b0,1'b0,1'b0,1'b0,2'd3,2'd0,1'b1,1'b1,2'd2,1'b0,1'b0,1'b0,2'd0}, NV, 1'b1);
    // R9: results hold after done
    run_vec(VEC[1], 1, 1'b0);
    repeat (5) @(negedge clk);
    check(nxt_valid === 1'b1 && nxt_addr === 32'h1001, "R9", nxt_addr, 32'h1001);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule